// File: doc/BRIEF.md
# Key-Locked Configuration Register Bank

This block holds the 32-bit control registers of a DRAM controller and serves them over a simple word-addressed read/write bus. Register index 0 is a protection register. While it holds the unlock key, software may write the other registers. While it holds any other value, writes to those registers are discarded and a one-cycle rejection pulse is raised. The protection register itself can be written at any time, so software unlocks by writing the key and relocks by writing anything else.

Register index 1 is the configuration word. Part of it is read-only, and which part depends on a static silicon-variant input. A write to this register updates only the writable bits. The read-only bits keep the value they were given at reset. That reset value carries a two-bit memory-size code, derived from a static memory-size input, plus fixed capability bits for each variant. Accesses to indices at or beyond the implemented register count do nothing, and reads of those indices return zero.

Top module: `cfgRegBank`

## Requirements
- R1: After reset, every register reads zero except index 1. With `revB`=0, index 1 reads 0x00000040 | sizeCode. With `revB`=1, it reads 0x1000000C | sizeCode. `locked` reads 1.
- R2: `locked` is 0 exactly when register index 0 holds 0xFC600309. Index 0 accepts every write, whatever the lock state. While unlocked, indices 1 to NUM_REGS-1 accept writes and read back the written data (index 1 subject to R5/R6).
- R3: While locked, a write to any index from 1 to NUM_REGS-1 leaves that register unchanged.
- R4: `writeRejected` is 1 for exactly the one cycle after a write that R3 discards. It stays 0 after accepted writes, after writes to index 0 and after writes to out-of-range indices.
- R5: With `revB`=0, the read-only mask of index 1 is 0xFFFFF84C. A write produces new = (old & mask) | (data & ~mask).
- R6: With `revB`=1, the read-only mask of index 1 is 0xF00FC04C. A write produces new = (old & mask) | (data & ~mask).
- R7: sizeCode is set as follows. With `revB`=0, 64/128/256/512 MB give code 0/1/2/3. With `revB`=1, 128/256/512/1024 MB give code 0/1/2/3. Any other `memSizeMb` gives code 2 on both variants, which is 256 MB on the first variant and 512 MB on the second.
- R8: A read at an index of NUM_REGS or above returns zero. A write at such an index changes no register.
- R9: `busRdata` takes the read value on the clock edge that accepts the read. It holds that value through idle cycles and through writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| revB | input | 1 | Static silicon variant: 0 first, 1 second |
| memSizeMb | input | 12 | Static installed memory size in MB |
| busValid | input | 1 | Access request this cycle |
| busWrite | input | 1 | 1 write, 0 read |
| busAddr | input | ADDR_W | Word index of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| locked | output | 1 | 1 while the unlock key is absent |
| writeRejected | output | 1 | One-cycle pulse after a discarded write |

## Verification
Two things can happen in the same clock edge: the lock check and the update of the protection register. A write to index 0 that changes the key is itself never gated. The write right after it is judged against the new value. The bench provokes this by writing a near-miss key while locked, then the real key, then index 1 in the very next access. It then relocks and writes again at once. Each of these accesses is judged by the rejection pulse one cycle later and by reading the target register back.

// File: rtl/cfgRegPkg.sv
package cfgRegPkg;
  localparam logic [31:0] UNLOCK_KEY = 32'hFC600309;
  localparam int PROT_IDX = 0;
  localparam int CONF_IDX = 1;
  localparam logic [31:0] RO_MASK_A = 32'hFFFFF84C;
  localparam logic [31:0] RO_MASK_B = 32'hF00FC04C;
  localparam logic [31:0] FIXED_A   = 32'h00000040;
  localparam logic [31:0] FIXED_B   = 32'h1000000C;

  typedef struct packed {
    logic wrEn;     // accepted write to the addressed register
    logic wrConf;   // accepted write targets the configuration word
    logic rdEn;     // read capture
    logic reject;   // write discarded by the lock
  } strobeT;

  function automatic logic [1:0] sizeCode(input logic revB, input logic [11:0] mb);
    logic [1:0] code;
    code = 2'd2;
    if (!revB) begin
      case (mb)
        12'd64:  code = 2'd0;
        12'd128: code = 2'd1;
        12'd256: code = 2'd2;
        12'd512: code = 2'd3;
        default: code = 2'd2;
      endcase
    end else begin
      case (mb)
        12'd128:  code = 2'd0;
        12'd256:  code = 2'd1;
        12'd512:  code = 2'd2;
        12'd1024: code = 2'd3;
        default:  code = 2'd2;
      endcase
    end
    return code;
  endfunction

  function automatic logic [31:0] roMask(input logic revB);
    return revB ? RO_MASK_B : RO_MASK_A;
  endfunction

  function automatic logic [31:0] confDefault(input logic revB, input logic [11:0] mb);
    return (revB ? FIXED_B : FIXED_A) | {30'd0, sizeCode(revB, mb)};
  endfunction
endpackage

// File: rtl/cfgRegCtrl.sv
module cfgRegCtrl
  import cfgRegPkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int ADDR_W   = 4
) (
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              keyMatch,
  output strobeT            strb
);
  localparam logic [ADDR_W:0] IDX_LIMIT = (ADDR_W+1)'(NUM_REGS);

  logic inRange;
  logic isProt;
  logic isConf;
  logic wrReq;

  always_comb begin
    inRange = {1'b0, busAddr} < IDX_LIMIT;
    isProt  = busAddr == ADDR_W'(PROT_IDX);
    isConf  = busAddr == ADDR_W'(CONF_IDX);
    wrReq   = busValid && busWrite && inRange;

    strb.wrEn   = wrReq && (isProt || keyMatch);
    strb.wrConf = wrReq && isConf && keyMatch;
    strb.rdEn   = busValid && !busWrite;
    strb.reject = wrReq && !isProt && !keyMatch;
  end
endmodule

// File: rtl/cfgRegDatapath.sv
module cfgRegDatapath
  import cfgRegPkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int ADDR_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              revB,
  input  logic [11:0]       memSizeMb,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  input  strobeT            strb,
  output logic              keyMatch,
  output logic [31:0]       busRdata,
  output logic              writeRejected
);
  logic [31:0] regFile [NUM_REGS];
  logic [31:0] rdMux;
  logic [31:0] confMask;
  logic [31:0] confReset;

  assign confMask  = roMask(revB);
  assign confReset = confDefault(revB, memSizeMb);

  for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
    logic hit;
    assign hit = strb.wrEn && (busAddr == ADDR_W'(g));
    if (g == CONF_IDX) begin : gConf
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)            regFile[g] <= confReset;
        else if (strb.wrConf) regFile[g] <= (regFile[g] & confMask) | (busWdata & ~confMask);
      end
    end else begin : gPlain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)    regFile[g] <= '0;
        else if (hit) regFile[g] <= busWdata;
      end
    end
  end

  always_comb begin
    rdMux = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (busAddr == ADDR_W'(i)) rdMux = regFile[i];
    end
  end

  assign keyMatch = regFile[PROT_IDX] == UNLOCK_KEY;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busRdata      <= '0;
      writeRejected <= 1'b0;
    end else begin
      writeRejected <= strb.reject;
      if (strb.rdEn) busRdata <= rdMux;
    end
  end
endmodule

// File: rtl/cfgRegBank.sv
module cfgRegBank
  import cfgRegPkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int ADDR_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              revB,
  input  logic [11:0]       memSizeMb,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              locked,
  output logic              writeRejected
);
  strobeT strb;
  logic   keyMatch;

  cfgRegCtrl #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) i_ctrl (
    .busValid (busValid),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .keyMatch (keyMatch),
    .strb     (strb)
  );

  cfgRegDatapath #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) i_dp (
    .clk           (clk),
    .rstN          (rstN),
    .revB          (revB),
    .memSizeMb     (memSizeMb),
    .busAddr       (busAddr),
    .busWdata      (busWdata),
    .strb          (strb),
    .keyMatch      (keyMatch),
    .busRdata      (busRdata),
    .writeRejected (writeRejected)
  );

  assign locked = !keyMatch;
endmodule

// File: rtl/cfgRegChecker.sv
module cfgRegChecker
  import cfgRegPkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int ADDR_W   = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              revB,
  input logic [11:0]       memSizeMb,
  input logic              busValid,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busWdata,
  input logic [31:0]       busRdata,
  input logic              locked,
  input logic              writeRejected
);
  localparam logic [ADDR_W:0] IDX_LIMIT = (ADDR_W+1)'(NUM_REGS);

  logic unusedWdata;
  assign unusedWdata = ^busWdata;

  // R4: a pulse only follows a locked write to a protected in-range index
  assert_reject_cause_R4: assert property (@(posedge clk) disable iff (!rstN)
    writeRejected |-> $past(busValid && busWrite && locked && busAddr != '0 &&
                            ({1'b0, busAddr} < IDX_LIMIT)));

  // R4: every locked write to a protected index is flagged on the next cycle
  assert_reject_seen_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite && locked && busAddr != '0 && ({1'b0, busAddr} < IDX_LIMIT))
      |=> writeRejected);

  // R2: the lock state moves only after a write to the protection register
  assert_lock_change_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(locked) |-> $past(busValid && busWrite && busAddr == '0));

  // R8: out-of-range reads give zero
  assert_oob_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite && !({1'b0, busAddr} < IDX_LIMIT)) |=> busRdata == '0);

  // R5 / R6: read-only bits of the configuration word never leave their reset value
  assert_conf_ro_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite && busAddr == ADDR_W'(CONF_IDX)) |=>
      ((busRdata & roMask(revB)) == (confDefault(revB, memSizeMb) & roMask(revB))));

  // R9: read data holds when no read is accepted
  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(busValid && !busWrite) |=> $stable(busRdata));
endmodule

bind cfgRegBank cfgRegChecker #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) i_chk (.*);

// File: tb/test_cfgRegBank.sv
`timescale 1ns/1ps
module test_cfgRegBank;
  localparam int NR = 8;
  localparam int AW = 4;
  localparam logic [31:0] KEY = 32'hFC600309;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rstN = 1'b0;
  logic          revB = 1'b0;
  logic [11:0]   memSizeMb = 12'd256;
  logic          busValid = 1'b0;
  logic          busWrite = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [31:0]   busWdata = '0;
  logic [31:0]   busRdata;
  logic          locked;
  logic          writeRejected;

  cfgRegBank #(.NUM_REGS(NR), .ADDR_W(AW)) i_cfgRegBank (.*);

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [31:0] expRegs [NR];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic endRun();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  function automatic logic [1:0] expCode(input logic v, input int mb);
    if (!v) begin
      if (mb == 64) return 2'd0;
      if (mb == 128) return 2'd1;
      if (mb == 256) return 2'd2;
      if (mb == 512) return 2'd3;
    end else begin
      if (mb == 128) return 2'd0;
      if (mb == 256) return 2'd1;
      if (mb == 512) return 2'd2;
      if (mb == 1024) return 2'd3;
    end
    return 2'd2;
  endfunction

  function automatic logic [31:0] expDefault(input logic v, input int mb);
    return (v ? 32'h1000000C : 32'h00000040) | {30'd0, expCode(v, mb)};
  endfunction

  task automatic doReset(input logic v, input int mb);
    @(negedge clk);
    rstN = 1'b0;
    revB = v;
    memSizeMb = 12'(mb);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d, output logic rej);
    busValid = 1'b1; busWrite = 1'b1; busAddr = AW'(a); busWdata = d;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
    rej = writeRejected;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    busValid = 1'b1; busWrite = 1'b0; busAddr = AW'(a);
    @(negedge clk);
    busValid = 1'b0;
    d = busRdata;
  endtask

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog act=running exp=done");
    endRun();
  end

  initial begin
    int sizes [7];
    logic [31:0] d;
    logic rej;
    logic [31:0] m;
    logic [31:0] pats [4];
    pats[0] = 32'hFFFFFFFF; pats[1] = 32'h00000000;
    pats[2] = 32'hA5A5A5A5; pats[3] = 32'h5A5A5A5A;

    for (int v = 0; v < 2; v++) begin
      sizes[0] = 64; sizes[1] = 128; sizes[2] = 256; sizes[3] = 512;
      sizes[4] = 1024; sizes[5] = 0; sizes[6] = 2048;
      m = v ? 32'hF00FC04C : 32'hFFFFF84C;

      // R7: size code and fallback sweep
      for (int s = 0; s < 7; s++) begin
        doReset(v[0], sizes[s]);
        rd(1, d);
        chk($sformatf("R7 v=%0d mb=%0d", v, sizes[s]), d, expDefault(v[0], sizes[s]));
      end

      // R1: reset state
      doReset(v[0], 512);
      chk("R1 locked after reset", {31'd0, locked}, 32'd1);
      chk("R1 reject idle", {31'd0, writeRejected}, 32'd0);
      for (int i = 0; i < NR; i++) begin
        expRegs[i] = (i == 1) ? expDefault(v[0], 512) : 32'h0;
        rd(i, d);
        chk($sformatf("R1 reg%0d", i), d, expRegs[i]);
      end

      // R3 / R4: locked writes discarded and flagged
      for (int i = 1; i < NR; i++) begin
        wr(i, 32'hDEAD0000 | i, rej);
        chk($sformatf("R4 reject reg%0d", i), {31'd0, rej}, 32'd1);
        rd(i, d);
        chk($sformatf("R3 locked reg%0d", i), d, expRegs[i]);
      end

      // R2: near-miss key keeps the lock; prot write never rejected
      wr(0, KEY ^ 32'h1, rej);
      chk("R4 prot write not rejected", {31'd0, rej}, 32'd0);
      chk("R2 wrong key locked", {31'd0, locked}, 32'd1);
      rd(0, d);
      chk("R2 prot readback", d, KEY ^ 32'h1);
      wr(0, KEY, rej);
      chk("R2 key unlocks", {31'd0, locked}, 32'd0);
      chk("R4 key write not rejected", {31'd0, rej}, 32'd0);

      // R5 / R6: masked configuration writes, first one right after unlock
      for (int p = 0; p < 4; p++) begin
        wr(1, pats[p], rej);
        chk("R4 accepted conf no pulse", {31'd0, rej}, 32'd0);
        expRegs[1] = (expRegs[1] & m) | (pats[p] & ~m);
        rd(1, d);
        chk(v ? $sformatf("R6 pat%0d", p) : $sformatf("R5 pat%0d", p), d, expRegs[1]);
      end

      // R2: unlocked plain registers take writes
      for (int i = 2; i < NR; i++) begin
        expRegs[i] = (32'h01010101 * i) ^ 32'h5A5A5A5A;
        wr(i, expRegs[i], rej);
        chk($sformatf("R4 accepted reg%0d", i), {31'd0, rej}, 32'd0);
        rd(i, d);
        chk($sformatf("R2 unlocked reg%0d", i), d, expRegs[i]);
      end
      expRegs[0] = KEY;

      // R8: out-of-range sweep
      for (int i = NR; i < (1 << AW); i++) begin
        wr(i, 32'hFFFFFFFF, rej);
        chk($sformatf("R4 oob%0d no pulse", i), {31'd0, rej}, 32'd0);
        rd(i, d);
        chk($sformatf("R8 oob%0d read", i), d, 32'h0);
      end
      for (int i = 0; i < NR; i++) begin
        rd(i, d);
        chk($sformatf("R8 reg%0d untouched", i), d, expRegs[i]);
      end

      // R9: read data holds over idle cycles and writes
      rd(3, d);
      repeat (3) @(negedge clk);
      chk("R9 hold idle", busRdata, expRegs[3]);
      wr(4, 32'h12345678, rej);
      expRegs[4] = 32'h12345678;
      chk("R9 hold over write", busRdata, expRegs[3]);

      // R2 / R3 / R4: relock then immediate write
      wr(0, 32'h0, rej);
      chk("R2 relocked", {31'd0, locked}, 32'd1);
      wr(2, 32'hCAFEF00D, rej);
      chk("R4 reject after relock", {31'd0, rej}, 32'd1);
      @(negedge clk);
      chk("R4 pulse one cycle", {31'd0, writeRejected}, 32'd0);
      rd(2, d);
      chk("R3 relocked reg2", d, expRegs[2]);
    end
    endRun();
  end
endmodule